// File: doc/BRIEF.md
# Cartridge-side bus-stuffing cycle sequencer

The block sits on the cartridge side of a 6502-family CPU bus that only exposes the address and data lines. It receives one strobe per CPU cycle, when the bus values are valid. It watches for the opcode fetch of a chosen instruction inside a cartridge address window. From that cycle on it counts bus cycles. On the cycles that it knows must be writes, it takes over the bus with values from a small queue of (low address, data) entries. The queue is filled by the cartridge's own logic.

In single mode the trigger is a 3-cycle zero-page store (opcode 0x85). On the third cycle only the data byte is replaced, so the CPU's own zero-page operand picks the target register. In quad mode the trigger is a 5-cycle zero-page read-modify-write (opcode 0x26). Both the dummy write on cycle 4 and the real write on cycle 5 have their low address byte and their data byte replaced. The cartridge therefore picks two target registers per instruction. Over a 76-cycle line this gives 25 register writes in single mode and 30 in quad mode.

If the queue is empty on a write cycle, the bus is left alone and a sticky underflow flag is raised.

Top module: `bus_stuffer`

## Requirements
- R1: While `rst_n` is low, and after reset, the sequencer is idle: `data_oe`, `addr_oe` and `underflow` are 0 and the queue is empty (`q_full` 0).
- R2: In single mode (`mode`=0), a strobe with idle state, `(addr_in & WIN_MASK) == WIN_MATCH` and `data_in` = 0x85 marks cycle 1. During cycle 3, the interval after the second strobe that follows, `data_oe`=1 and `data_out` equals the data byte of the oldest queue entry. `addr_oe` stays 0, and the strobe that ends cycle 3 removes that entry.
- R3: During cycles 1 and 2 of a single-mode store, and during cycles 1 to 3 of a quad-mode instruction, `data_oe` and `addr_oe` are 0.
- R4: In quad mode (`mode`=1), a fetch of opcode 0x26 in the window starts a 5-cycle sequence. During cycles 4 and 5, `addr_oe` and `data_oe` are both 1, and `addr_out`/`data_out` carry the low address byte and the data byte of the oldest entry. Each of these two cycles removes one entry.
- R5: A strobe that does not start a sequence has no effect on the bus or the queue: an address outside the window, an opcode other than the one for the current mode, or a non-strobe clock.
- R6: Bytes that equal an opcode but are seen during cycles 2 to 5 do not restart the sequence. After the final cycle the block is idle, and it recognises a fetch on the very next strobe, so instructions can run back to back.
- R7: If the queue is empty on a write cycle, `data_oe` and `addr_oe` stay 0 and `underflow` becomes 1. It stays 1 until reset.
- R8: Entries come out in push order. A push (`push_valid` on a clock edge) is taken only when `q_full` is 0 and is dropped otherwise. `q_full` is 1 when the queue holds DEPTH entries.
- R9: The mode is sampled at the opcode fetch. A change of `mode` during a sequence does not alter that sequence's length or its write cycles.
- R10: The sequencer advances only on strobe clocks. Outputs that are driving stay driving with the same value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | One-clock pulse per CPU cycle; bus inputs valid |
| mode | input | 1 | 0 single-store mode, 1 quad read-modify-write mode |
| addr_in | input | ADDR_W | CPU address bus |
| data_in | input | 8 | CPU data bus as seen by the cartridge |
| push_valid | input | 1 | Add an entry to the queue |
| push_addr | input | 8 | Low address byte of the pushed entry |
| push_data | input | 8 | Data byte of the pushed entry |
| q_full | output | 1 | Queue holds DEPTH entries |
| data_oe | output | 1 | Drive data_out onto the data bus |
| data_out | output | 8 | Override data byte (meaningful when data_oe) |
| addr_oe | output | 1 | Drive addr_out onto the low address bus |
| addr_out | output | 8 | Override low address byte (meaningful when addr_oe) |
| underflow | output | 1 | Sticky: a write cycle found the queue empty |

## Verification
A cycle counter that is off by one would shift `data_oe` into the wrong interval: onto an operand fetch or a zero-page read, or one cycle past the write. That shows at the ports within one instruction. A mode latched at the wrong time changes the number of driven cycles, and so the number of entries consumed. Queue pointer or count faults appear as a wrong `data_out`/`addr_out` pairing, or as a `q_full` or `underflow` edge that comes too early or too late. The per-clock reference comparison reports these on the first clock where they differ.

// File: rtl/bus_stuffer.sv
module bus_stuffer #(
  parameter int          ADDR_W    = 13,
  parameter int          DEPTH     = 8,
  parameter logic [12:0] WIN_MASK  = 13'h1000,
  parameter logic [12:0] WIN_MATCH = 13'h1000,
  parameter logic [7:0]  OP_SINGLE = 8'h85,
  parameter logic [7:0]  OP_QUAD   = 8'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  input  logic              push_valid,
  input  logic [7:0]        push_addr,
  input  logic [7:0]        push_data,
  output logic              q_full,
  output logic              data_oe,
  output logic [7:0]        data_out,
  output logic              addr_oe,
  output logic [7:0]        addr_out,
  output logic              underflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [2:0]    phase;
  logic          qmode;

  wire empty    = (count == '0);
  assign q_full = (count == FULL_CNT);

  wire in_win   = ((addr_in & WIN_MASK[ADDR_W-1:0]) == WIN_MATCH[ADDR_W-1:0]);
  wire op_hit   = (data_in == (mode ? OP_QUAD : OP_SINGLE));
  wire trigger  = cyc_stb && (phase == 3'd0) && in_win && op_hit;
  wire [2:0] last_ph = qmode ? 3'd5 : 3'd3;
  wire wr_cyc   = qmode ? (phase == 3'd4 || phase == 3'd5) : (phase == 3'd3);

  wire push_ok  = push_valid && !q_full;
  wire pop      = cyc_stb && wr_cyc && !empty;
  wire starve   = cyc_stb && wr_cyc && empty;

  assign data_oe  = wr_cyc && !empty;
  assign addr_oe  = data_oe && qmode;
  assign data_out = mem[rd_ptr][7:0];
  assign addr_out = mem[rd_ptr][15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 3'd0;
      qmode <= 1'b0;
    end else if (trigger) begin
      phase <= 3'd2;
      qmode <= mode;
    end else if (cyc_stb && phase != 3'd0) begin
      phase <= (phase == last_ph) ? 3'd0 : phase + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) underflow <= 1'b0;
    else if (starve) underflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bus_stuffer_chk.sv
module bus_stuffer_chk #(parameter int CW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_stb,
  input logic          push_valid,
  input logic          q_full,
  input logic          data_oe,
  input logic [7:0]    data_out,
  input logic          addr_oe,
  input logic          underflow,
  input logic [2:0]    phase,
  input logic [CW-1:0] count
);
  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R4
  addr_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> data_oe);

  // R10
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_stb && data_oe) |=> (data_oe && $stable(data_out)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase < 3'd3) |-> (!data_oe && !addr_oe));

  // R8
  pop_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && data_oe && !push_valid) |=> (count == $past(count) - 1'b1));

  // R6
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && phase == 3'd5) |=> (phase == 3'd0));

  // R8
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !(cyc_stb && data_oe)) |=> q_full);
endmodule

bind bus_stuffer bus_stuffer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .push_valid(push_valid),
  .q_full(q_full), .data_oe(data_oe), .data_out(data_out), .addr_oe(addr_oe),
  .underflow(underflow), .phase(phase), .count(count)
);

// File: tb/bus_stuffer_test.sv
`timescale 1ns/1ps
module bus_stuffer_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_stb = 1'b0, mode = 1'b0, push_valid = 1'b0;
  logic [12:0] addr_in = '0;
  logic [7:0] data_in = '0, push_addr = '0, push_data = '0;
  logic q_full, data_oe, addr_oe, underflow;
  logic [7:0] data_out, addr_out;

  bus_stuffer uut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .mode(mode),
    .addr_in(addr_in), .data_in(data_in), .push_valid(push_valid),
    .push_addr(push_addr), .push_data(push_data), .q_full(q_full),
    .data_oe(data_oe), .data_out(data_out), .addr_oe(addr_oe),
    .addr_out(addr_out), .underflow(underflow)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  logic [15:0] q[$];
  int ph = 0;
  bit m = 0, uf = 0;

  function automatic bit m_wr();
    return m ? (ph == 4 || ph == 5) : (ph == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); ph = 0; m = 0; uf = 0;
    end else begin
      bit was_empty, was_full;
      was_empty = (q.size() == 0);
      was_full  = (q.size() == DEPTH);
      if (cyc_stb) begin
        if (m_wr()) begin
          if (!was_empty) void'(q.pop_front());
          else uf = 1;
        end
        if (ph == 0) begin
          if (addr_in[12] && data_in == (mode ? 8'h26 : 8'h85)) begin
            ph = 2; m = mode;
          end
        end else if (ph == (m ? 5 : 3)) ph = 0;
        else ph = ph + 1;
      end
      if (push_valid && !was_full) q.push_back({push_addr, push_data});
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit eo;
      eo = m_wr() && q.size() > 0;
      cmp("data_oe", int'(data_oe), int'(eo));
      cmp("addr_oe", int'(addr_oe), int'(eo && m));
      cmp("underflow", int'(underflow), int'(uf));
      cmp("q_full", int'(q_full), int'(q.size() == DEPTH));
      if (eo) begin
        cmp("data_out", int'(data_out), int'(q[0][7:0]));
        if (m) cmp("addr_out", int'(addr_out), int'(q[0][15:8]));
      end
    end
  end

  task automatic cyc(input logic [12:0] a, input logic [7:0] d);
    cyc_stb = 1'b1; addr_in = a; data_in = d;
    @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  task automatic gap(input int n);
    cyc_stb = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] d);
    push_valid = 1'b1; push_addr = a; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic single_store(input logic [7:0] zp);
    cyc(13'h1000, 8'h85); cyc(13'h1001, zp); cyc({5'd0, zp}, 8'h00);
  endtask

  task automatic quad_rmw(input logic [7:0] zp);
    cyc(13'h1010, 8'h26); cyc(13'h1011, zp); cyc({5'd0, zp}, 8'h11);
    cyc({5'd0, zp}, 8'h11); cyc({5'd0, zp}, 8'h22);
  endtask

  task summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    gap(2);

    tag = "R8";
    for (int i = 0; i < 6; i++) push(8'h02 + 8'(i), 8'hA0 + 8'(i));

    tag = "R2"; mode = 0;
    single_store(8'h06);
    gap(1);
    tag = "R3";
    single_store(8'h07);

    tag = "R4"; mode = 1;
    quad_rmw(8'h80);
    gap(1);

    tag = "R5";
    mode = 0; cyc(13'h0000, 8'h85); cyc(13'h0001, 8'h00); cyc(13'h0002, 8'h00);
    cyc(13'h1000, 8'h26); cyc(13'h1001, 8'h00); cyc(13'h0001, 8'h00);
    mode = 1; cyc(13'h1000, 8'h85); cyc(13'h1001, 8'h00); cyc(13'h0001, 8'h00);
    gap(3);

    tag = "R6";
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i), 8'hC0 + 8'(i));
    mode = 1;
    cyc(13'h1000, 8'h26); cyc(13'h1001, 8'h26); cyc(13'h1026, 8'h26);
    cyc(13'h1026, 8'h26); cyc(13'h1026, 8'h26);
    quad_rmw(8'h81);

    tag = "R9";
    for (int i = 0; i < 3; i++) push(8'h20 + 8'(i), 8'h50 + 8'(i));
    mode = 0;
    cyc(13'h1000, 8'h85); mode = 1; cyc(13'h1001, 8'h06); cyc(13'h0006, 8'h00);
    cyc(13'h0006, 8'h00); cyc(13'h0006, 8'h00);
    mode = 1;
    cyc(13'h1000, 8'h26); mode = 0; cyc(13'h1001, 8'h81); cyc(13'h0081, 8'h00);
    cyc(13'h0081, 8'h00); cyc(13'h0081, 8'h00);

    tag = "R10";
    push(8'h30, 8'h31); push(8'h32, 8'h33);
    mode = 1;
    cyc(13'h1000, 8'h26); gap(2); cyc(13'h1001, 8'h82); gap(1);
    cyc(13'h0082, 8'h00); gap(2); cyc(13'h0082, 8'h00); gap(3);
    cyc(13'h0082, 8'h00); gap(2);

    tag = "R7";
    mode = 1;
    quad_rmw(8'h83);
    push(8'h40, 8'h41);
    mode = 0;
    single_store(8'h08);
    gap(2);

    tag = "R8";
    for (int i = 0; i < DEPTH + 3; i++) push(8'h60 + 8'(i), 8'h70 + 8'(i));
    mode = 1;
    for (int i = 0; i < 5; i++) quad_rmw(8'h84);
    gap(2);

    tag = "R1";
    rst_n = 1'b0;
    gap(3);
    rst_n = 1'b1;
    gap(2);

    summary();
  end
endmodule